// File: doc/BRIEF.md
# Register-Slot Descriptor Ring Engine

This block is the descriptor engine for one direction of an Ethernet MAC. It does not fetch descriptors from memory. Four descriptor slots are held in hardware registers, 16 bytes apart. Each slot has three words: a status word, a control word and, in the transmit variant, a length word. The control word carries the 64-byte aligned buffer address in its upper bits. Its low bits hold the enable flag, the done flag and the engine's current slot index.

Software passes a slot to the engine by writing its control word with the enable flag set. The engine works on one slot at a time and visits them in the fixed order 0, 1, 2, 3, then back to 0. While the current slot is enabled, the engine presents that slot's buffer address and length to the frame side. When the frame side reports a finished frame, the engine does four things: it stores the reported status, clears enable, sets done and raises a one-cycle interrupt, and then moves to the next slot. A parameter selects the variant. In the receive variant, a frame that arrives while the current slot is not enabled is dropped, and a missed-frame mark is added to the next status the engine stores. In the transmit variant, such a completion is ignored.

Top module: `dring_top`

## Requirements
- R1: After reset, every slot has enable and done cleared and all-zero status and length. The current index is 0, `slotReady` is low and `irqPulse` is low.
- R2: The control word at slot offset +4 reads back as follows: bit 0 is enable, bit 1 is done, bits 3:2 are the current slot index and bits 5:4 are 0. Bits 31:6 are the stored buffer address. The low 6 bits of a written value never become part of the address.
- R3: `slotReady` is high exactly when the current slot is enabled. `bufAddr` is that slot's address with its low 6 bits zero.
- R4: If `frmDone` is high at a clock edge while `slotReady` is high, then after that edge the current slot holds `frmStatus` at offset +0, its enable is clear and its done is set. `irqPulse` is high for exactly that one cycle.
- R5: Each completion moves the current index by one in the order 0, 1, 2, 3, 0. The index changes at no other time except reset.
- R6: In the transmit variant (IS_RX=0), `frmDone` while the current slot is not enabled changes no slot, no index and no interrupt.
- R7: In the receive variant (IS_RX=1), `frmDone` while the current slot is not enabled drops the frame, with no index change and no interrupt. The next completed slot stores `frmStatus` with bit 31 forced to 1. Completions after that one store the status unchanged.
- R8: A software write to a control word copies bit 0 into enable. It can clear done when bit 1 is 0, but it can never set done.
- R9: In the transmit variant, the length word at offset +8 holds the low LEN_W bits written and drives `bufLen` for the current slot. In the receive variant, writes to it are ignored and it reads 0.
- R10: Software writes to a status word are ignored.
- R11: If a completion and a software write to the current slot's control word happen at the same edge, the completion decides enable (cleared) and done (set). The written address is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (controller reset) |
| regWrEn | input | 1 | Software register write strobe |
| regAddr | input | REG_AW (6) | Byte offset of register, slot*16 + word*4 |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at `regAddr` |
| slotReady | output | 1 | Current slot is enabled |
| bufAddr | output | 32 | Buffer address of current slot |
| bufLen | output | LEN_W (16) | Length word of current slot |
| frmDone | input | 1 | Frame finished (transmit) or arrived (receive) |
| frmStatus | input | 32 | Status to store for that frame |
| irqPulse | output | 1 | One-cycle completion pulse |
| curIdx | output | IDX_W (2) | Current slot index |

## Verification
The transmit instance first completes one frame and then completes four more in a row. This shows the wrap from slot 3 back to 0 and that each status lands in the slot that was current, not in a neighbour. A completion against a disabled slot is compared with one against an enabled slot, which separates ignoring a frame from serving it. The receive instance sends a dropped frame, then two served frames, to show that the missed mark goes onto exactly one status. A completion that lands at the same edge as a software write to the same slot checks which source wins each field.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int BufLsb   = 6;
  localparam int MissBit  = 31;
  localparam int EnBit    = 0;
  localparam int DoneBit  = 1;

  typedef struct packed {
    logic complete;
    logic markMissed;
  } ringStrobeT;
endpackage

// File: rtl/dring_ctrl.sv
module dring_ctrl
  import dring_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter bit IS_RX = 1'b0,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmDone,
  input  logic             curEnabled,
  output logic [IDX_W-1:0] curIdx,
  output logic             irqPulse,
  output ringStrobeT       strobe
);
  logic missPend;
  logic dropNow;

  always_comb begin
    strobe.complete   = frmDone & curEnabled;
    strobe.markMissed = frmDone & curEnabled & missPend;
    dropNow           = frmDone & ~curEnabled & IS_RX;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      irqPulse <= 1'b0;
      missPend <= 1'b0;
    end else begin
      irqPulse <= strobe.complete;
      if (strobe.complete) begin
        curIdx   <= (curIdx == IDX_W'(SLOTS - 1)) ? '0 : curIdx + 1'b1;
        missPend <= 1'b0;
      end else if (dropNow) begin
        missPend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LEN_W = 16,
  parameter bit IS_RX = 1'b0,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int REG_AW = IDX_W + 4,
  localparam int BUF_W  = 32 - BufLsb
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [IDX_W-1:0]  curIdx,
  input  ringStrobeT        strobe,
  input  logic [31:0]       frmStatus,
  output logic              curEnabled,
  output logic [31:0]       bufAddr,
  output logic [LEN_W-1:0]  bufLen
);
  logic [31:0]      statusArr [SLOTS];
  logic [BUF_W-1:0] bufArr    [SLOTS];
  logic [LEN_W-1:0] lenArr    [SLOTS];
  logic [SLOTS-1:0] enArr;
  logic [SLOTS-1:0] doneArr;

  logic [IDX_W-1:0] selSlot;
  logic [1:0]       selWord;
  logic             aligned;
  logic [31:0]      doneStatus;

  assign selSlot    = regAddr[REG_AW-1:4];
  assign selWord    = regAddr[3:2];
  assign aligned    = (regAddr[1:0] == 2'b00);
  assign doneStatus = frmStatus | ({31'b0, strobe.markMissed} << MissBit);

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic [31:0]      statusQ;
    logic [BUF_W-1:0] bufQ;
    logic [LEN_W-1:0] lenQ;
    logic             enQ;
    logic             doneQ;
    logic             hit;
    logic             finish;

    assign hit    = wrEn && aligned && (selSlot == IDX_W'(s));
    assign finish = strobe.complete && (curIdx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ <= '0;
        bufQ    <= '0;
        lenQ    <= '0;
        enQ     <= 1'b0;
        doneQ   <= 1'b0;
      end else begin
        if (hit && selWord == 2'd1) begin
          bufQ  <= wrData[31:BufLsb];
          enQ   <= wrData[EnBit];
          doneQ <= doneQ & wrData[DoneBit];
        end
        if (hit && selWord == 2'd2 && !IS_RX) lenQ <= wrData[LEN_W-1:0];
        if (finish) begin
          statusQ <= doneStatus;
          enQ     <= 1'b0;
          doneQ   <= 1'b1;
        end
      end
    end

    assign statusArr[s] = statusQ;
    assign bufArr[s]    = bufQ;
    assign lenArr[s]    = lenQ;
    assign enArr[s]     = enQ;
    assign doneArr[s]   = doneQ;
  end

  always_comb begin
    rdData = '0;
    if (aligned) begin
      case (selWord)
        2'd0:    rdData = statusArr[selSlot];
        2'd1:    rdData = {bufArr[selSlot], 2'b00, 2'(curIdx), doneArr[selSlot], enArr[selSlot]};
        2'd2:    rdData = {{(32 - LEN_W){1'b0}}, lenArr[selSlot]};
        default: rdData = '0;
      endcase
    end
  end

  assign curEnabled = enArr[curIdx];
  assign bufAddr    = {bufArr[curIdx], {BufLsb{1'b0}}};
  assign bufLen     = lenArr[curIdx];
endmodule

// File: rtl/dring_top.sv
module dring_top
  import dring_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LEN_W = 16,
  parameter bit IS_RX = 1'b0,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int REG_AW = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              slotReady,
  output logic [31:0]       bufAddr,
  output logic [LEN_W-1:0]  bufLen,
  input  logic              frmDone,
  input  logic [31:0]       frmStatus,
  output logic              irqPulse,
  output logic [IDX_W-1:0]  curIdx
);
  ringStrobeT strobe;

  dring_ctrl #(.SLOTS(SLOTS), .IS_RX(IS_RX)) uCtrl (
    .clk(clk), .rstN(rstN), .frmDone(frmDone), .curEnabled(slotReady),
    .curIdx(curIdx), .irqPulse(irqPulse), .strobe(strobe)
  );

  dring_regs #(.SLOTS(SLOTS), .LEN_W(LEN_W), .IS_RX(IS_RX)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .regAddr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .curIdx(curIdx),
    .strobe(strobe), .frmStatus(frmStatus), .curEnabled(slotReady),
    .bufAddr(bufAddr), .bufLen(bufLen)
  );
endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             frmDone,
  input logic             slotReady,
  input logic             irqPulse,
  input logic [IDX_W-1:0] curIdx
);
  assert_served_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frmDone && slotReady) |=> irqPulse);

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  assert_idx_moves_only_on_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curIdx) |-> irqPulse);

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (curIdx == IDX_W'($past(curIdx) + 1'b1)));

  assert_unready_no_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frmDone && !slotReady) |=> !irqPulse);
endmodule

bind dring_top dring_chk #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .frmDone(frmDone), .slotReady(slotReady),
  .irqPulse(irqPulse), .curIdx(curIdx)
);

// File: tb/tb_dring_top.sv
module tb_dring_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        wrT = 1'b0, wrR = 1'b0, doneT = 1'b0, doneR = 1'b0;
  logic [5:0]  adrT = '0, adrR = '0;
  logic [31:0] wdT = '0, wdR = '0, stT = '0, stR = '0;
  logic [31:0] rdT, rdR, baT, baR;
  logic [15:0] blT, blR;
  logic        rdyT, rdyR, irqT, irqR;
  logic [1:0]  idxT, idxR;

  dring_top #(.IS_RX(1'b0)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(wrT), .regAddr(adrT), .regWrData(wdT),
    .regRdData(rdT), .slotReady(rdyT), .bufAddr(baT), .bufLen(blT),
    .frmDone(doneT), .frmStatus(stT), .irqPulse(irqT), .curIdx(idxT));

  dring_top #(.IS_RX(1'b1)) dutRx (
    .clk(clk), .rstN(rstN), .regWrEn(wrR), .regAddr(adrR), .regWrData(wdR),
    .regRdData(rdR), .slotReady(rdyR), .bufAddr(baR), .bufLen(blR),
    .frmDone(doneR), .frmStatus(stR), .irqPulse(irqR), .curIdx(idxR));

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit rx, logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    if (rx) begin wrR = 1; adrR = a; wdR = d; end
    else    begin wrT = 1; adrT = a; wdT = d; end
    @(negedge clk);
    wrR = 0; wrT = 0;
  endtask

  task automatic rd(bit rx, logic [5:0] a, output logic [31:0] d);
    if (rx) adrR = a; else adrT = a;
    #1;
    d = rx ? rdR : rdT;
  endtask

  // One-cycle completion; returns at the negedge right after the edge that took it.
  task automatic finishFrame(bit rx, logic [31:0] st);
    @(negedge clk);
    if (rx) begin doneR = 1; stR = st; end else begin doneT = 1; stT = st; end
    @(negedge clk);
    doneR = 0; doneT = 0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 idx", {30'b0, idxT}, 0);
    check("R1 ready", {31'b0, rdyT}, 0);
    check("R1 irq", {31'b0, irqT}, 0);
    for (int s = 0; s < 4; s++) begin
      rd(0, 6'(s * 16 + 4), v); check("R1 ctrl", v, 0);
      rd(0, 6'(s * 16), v);     check("R1 status", v, 0);
      rd(0, 6'(s * 16 + 8), v); check("R1 len", v, 0);
    end
  endtask

  task automatic testLayout();
    logic [31:0] v;
    wr(0, 6'h04, 32'h1234_567F);
    rd(0, 6'h04, v); check("R2 ctrl layout", v, 32'h1234_5641);
    check("R3 ready", {31'b0, rdyT}, 1);
    check("R3 bufAddr", baT, 32'h1234_5640);
    wr(0, 6'h08, 32'hABCD_05DC);
    rd(0, 6'h08, v); check("R9 len word", v, 32'h0000_05DC);
    check("R9 bufLen", {16'b0, blT}, 32'h05DC);
  endtask

  task automatic testComplete();
    logic [31:0] v;
    finishFrame(0, 32'h8000_0C01);
    check("R4 irq high", {31'b0, irqT}, 1);
    check("R5 idx 1", {30'b0, idxT}, 1);
    rd(0, 6'h00, v); check("R4 status", v, 32'h8000_0C01);
    rd(0, 6'h04, v); check("R4 ctrl done", v, 32'h1234_5646);
    @(negedge clk);
    check("R4 irq one cycle", {31'b0, irqT}, 0);
  endtask

  task automatic testIgnoreTx();
    logic [31:0] v;
    finishFrame(0, 32'hDEAD_BEEF);
    check("R6 no irq", {31'b0, irqT}, 0);
    check("R6 idx kept", {30'b0, idxT}, 1);
    rd(0, 6'h10, v); check("R6 status untouched", v, 0);
    rd(0, 6'h14, v); check("R6 ctrl untouched", v, 32'h0000_0004);
  endtask

  task automatic testDoneAck();
    logic [31:0] v;
    wr(0, 6'h04, 32'h1234_5642);
    rd(0, 6'h04, v); check("R8 done kept", v, 32'h1234_5646);
    wr(0, 6'h04, 32'h1234_5640);
    rd(0, 6'h04, v); check("R8 done cleared", v, 32'h1234_5644);
    wr(0, 6'h00, 32'hFFFF_FFFF);
    rd(0, 6'h00, v); check("R10 status write ignored", v, 32'h8000_0C01);
  endtask

  task automatic testWrap();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      int s = (k + 1) % 4;
      wr(0, 6'(s * 16 + 4), 32'h0001_0000 * (k + 1) | 32'h1);
    end
    for (int k = 0; k < 4; k++) begin
      int s = (k + 1) % 4;
      check("R3 bufAddr in turn", baT, 32'h0001_0000 * (k + 1));
      finishFrame(0, 32'h100 + k);
      check("R5 wrap order", {30'b0, idxT}, 32'((s + 1) % 4));
    end
    for (int k = 0; k < 4; k++) begin
      int s = (k + 1) % 4;
      rd(0, 6'(s * 16), v); check("R5 per-slot status", v, 32'h100 + k);
    end
  endtask

  task automatic testCollide();
    logic [31:0] v;
    wr(0, 6'h14, 32'h0000_1001);
    @(negedge clk);
    doneT = 1; stT = 32'h55; wrT = 1; adrT = 6'h14; wdT = 32'h0000_2001;
    @(negedge clk);
    doneT = 0; wrT = 0;
    check("R11 idx", {30'b0, idxT}, 2);
    rd(0, 6'h14, v); check("R11 ctrl", v, 32'h0000_200A);
    rd(0, 6'h10, v); check("R11 status", v, 32'h55);
  endtask

  task automatic testRx();
    logic [31:0] v;
    wr(1, 6'h08, 32'h0000_0123);
    rd(1, 6'h08, v); check("R9 rx len ignored", v, 0);
    finishFrame(1, 32'h0000_0040);
    check("R7 drop no irq", {31'b0, irqR}, 0);
    check("R7 drop idx", {30'b0, idxR}, 0);
    rd(1, 6'h00, v); check("R7 drop no status", v, 0);
    wr(1, 6'h04, 32'h0000_4001);
    wr(1, 6'h14, 32'h0000_8001);
    finishFrame(1, 32'h0000_0040);
    check("R7 irq", {31'b0, irqR}, 1);
    rd(1, 6'h00, v); check("R7 missed mark", v, 32'h8000_0040);
    finishFrame(1, 32'h0000_0044);
    rd(1, 6'h10, v); check("R7 mark once", v, 32'h0000_0044);
    check("R7 idx", {30'b0, idxR}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testLayout();
    testComplete();
    testIgnoreTx();
    testDoneAck();
    testWrap();
    testCollide();
    testRx();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule